// File: doc/BRIEF.md
# Push-Button Fan Speed Stepper

This block steps a ceiling fan through six states, off and five speeds, with one push button. The raw button level is brought into the clock domain and filtered against contact bounce. Each accepted press then yields a single advance strobe. A three-bit speed state moves forward one step per strobe and returns from the top speed to off. The state is decoded into one relay-enable line per speed and into an active-high seven-segment pattern that shows the speed digit.

The block sits between a panel button and the relay driver and display driver stages. A control module handles synchronisation, filtering and strobe generation. A datapath module holds the speed state and the registered decodes. The two modules talk through a small strobe struct.

Top module: `fan_speed_stepper`

## Requirements
- R1: After a synchronous reset the speed state is 0: every relay enable is low and the display shows the digit 0 (pattern 7'h7E).
- R2: Each accepted press advances the speed state by exactly one, in the order 0,1,2,3,4,5.
- R3: A press accepted while the state is 5 returns it to 0. The states 6 and 7 never appear on any output.
- R4: In state N (1 to 5) only relayEn[N-1] is high. In state 0 all five enables are low. At most one enable is high in any cycle.
- R5: segOut is active-high with segOut[6]=a down to segOut[0]=g. The digits 0..5 read 7E, 30, 6D, 79, 33, 5B (hex). Any other state value gives 00.
- R6: A button level is accepted only after the synchronised input has held it for STABLE_CYCLES clock cycles. Pulses or gaps of STABLE_CYCLES-3 cycles or fewer have no effect.
- R7: Releasing the button never advances the state. A press held for any length advances it exactly once.
- R8: The state changes on the falling edge of the internal advance strobe. After the button settles high, the outputs keep their old value for at least STABLE_CYCLES cycles and show the new speed within STABLE_CYCLES+5 cycles.
- R9: Asserting rst at any time returns the state to 0 and clears all relay enables on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| buttonRaw | input | 1 | Unsynchronised, bouncy push-button level, high while pressed |
| relayEn | output | 5 | Relay enables; bit N-1 is high for speed N |
| segOut | output | 7 | Seven-segment pattern, bit 6 = a, bit 0 = g, active high |

## Verification
The assertions assume that rst is driven synchronously, and that buttonRaw may change at any time but is only trusted after the synchroniser. They also assume that a real press holds its level far longer than STABLE_CYCLES. The stimulus changes buttonRaw only between clock edges. Random bounce bursts are kept at STABLE_CYCLES-3 cycles or shorter, and every intended press or release is held for at least STABLE_CYCLES+6 cycles. This keeps each press unambiguous, so the expected speed can be counted press by press.

// File: rtl/fan_step_pkg.sv
package fan_step_pkg;
  // Fixed by the product: off plus five speeds
  localparam int SPEED_LEVELS = 5;
  localparam int STATE_COUNT  = SPEED_LEVELS + 1;
  localparam int COUNT_W      = $clog2(STATE_COUNT);
  localparam int SEG_W        = 7;
  localparam int DECODE_W     = 1 << COUNT_W;

  typedef logic [COUNT_W-1:0] speedState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic clear;
  } stepStrobes_t;

  // Active-high segments, bit 6 = a ... bit 0 = g; unused codes blank
  function automatic logic [SEG_W-1:0] digitToSeg(input speedState_t d);
    logic [SEG_W-1:0] pat;
    case (d)
      speedState_t'(0): pat = 7'h7E;
      speedState_t'(1): pat = 7'h30;
      speedState_t'(2): pat = 7'h6D;
      speedState_t'(3): pat = 7'h79;
      speedState_t'(4): pat = 7'h33;
      speedState_t'(5): pat = 7'h5B;
      default:          pat = 7'h00;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/button_conditioner.sv
module button_conditioner
  import fan_step_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 5000000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buttonRaw,
  output stepStrobes_t strobes
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLevel;
  logic                   debState;
  logic [CNT_W-1:0]       stableCnt;
  logic                   advPulse;

  // Synchroniser chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= buttonRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], buttonRaw};
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];

  // Stability filter: a new level is accepted after STABLE_CYCLES cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      debState  <= 1'b0;
      stableCnt <= '0;
      advPulse  <= 1'b0;
    end else begin
      advPulse <= 1'b0;
      if (syncLevel == debState) begin
        stableCnt <= '0;
      end else if (stableCnt == LAST_CNT) begin
        stableCnt <= '0;
        debState  <= syncLevel;
        advPulse  <= syncLevel;   // press edge only; release gives nothing
      end else begin
        stableCnt <= stableCnt + CNT_W'(1);
      end
    end
  end

  assign strobes.advance = advPulse;
  assign strobes.clear   = rst;

  // R7: an advance strobe lasts one cycle
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    advPulse |=> !advPulse);
  // R7: a strobe only accompanies the pressed level
  p_pulse_on_press_r7: assert property (@(posedge clk) disable iff (rst)
    advPulse |-> debState);
  // R6: the filtered level only ever moves toward the synchronised level
  p_filter_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (debState != $past(debState)) |-> (debState == syncLevel));
  // R6: the filter counter stays below its limit
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    stableCnt <= LAST_CNT);
endmodule

// File: rtl/speed_datapath.sv
module speed_datapath
  import fan_step_pkg::*;
(
  input  logic                    clk,
  input  stepStrobes_t            strobes,
  output logic [SPEED_LEVELS-1:0] relayEn,
  output logic [SEG_W-1:0]        segOut
);
  speedState_t               speedState;
  speedState_t               stepValue;
  logic                      advDly;
  logic                      advFall;
  logic                      wrapHit;
  logic [DECODE_W-1:0]       decodeN;
  logic [SPEED_LEVELS-1:0]   relayNext;

  // Falling edge of the advance strobe clocks the state
  assign advFall   = advDly && !strobes.advance;
  assign stepValue = speedState + speedState_t'(1);
  // With six states the value 6 is the first with both upper bits set
  assign wrapHit   = stepValue[COUNT_W-1] & stepValue[COUNT_W-2];

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      advDly     <= 1'b0;
      speedState <= '0;
    end else begin
      advDly <= strobes.advance;
      if (advFall) speedState <= wrapHit ? '0 : stepValue;
    end
  end

  // Active-low full decode, then inversion per relay line
  generate
    for (genvar j = 0; j < DECODE_W; j++) begin : g_dec
      assign decodeN[j] = ~(speedState == speedState_t'(j));
    end
    for (genvar i = 0; i < SPEED_LEVELS; i++) begin : g_relay
      assign relayNext[i] = ~decodeN[i+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      relayEn <= '0;
      segOut  <= digitToSeg('0);
    end else begin
      relayEn <= relayNext;
      segOut  <= digitToSeg(speedState);
    end
  end

  // R4: never two relays at once
  p_relay_onehot_r4: assert property (@(posedge clk) disable iff (strobes.clear)
    $onehot0(relayEn));
  // R3: the state never reaches an unused value
  p_state_range_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    speedState < speedState_t'(STATE_COUNT));
  // R3: the top speed wraps to off
  p_wrap_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    (advFall && speedState == speedState_t'(SPEED_LEVELS)) |=> speedState == '0);
  // R2: a falling strobe edge advances by one below the top
  p_step_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    (advFall && speedState < speedState_t'(SPEED_LEVELS)) |=>
      speedState == $past(speedState) + speedState_t'(1));
  // R8: without a falling strobe edge the state holds
  p_hold_r8: assert property (@(posedge clk) disable iff (strobes.clear)
    !advFall |=> $stable(speedState));
  // R4: off state gives no relay one cycle later
  p_off_norelay_r4: assert property (@(posedge clk) disable iff (strobes.clear)
    (speedState == '0) |=> relayEn == '0);
  // R9: clear forces the state to off
  p_clear_r9: assert property (@(posedge clk)
    strobes.clear |=> (speedState == '0 && relayEn == '0));
endmodule

// File: rtl/fan_speed_stepper.sv
module fan_speed_stepper
  import fan_step_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 5000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       buttonRaw,
  output logic [4:0] relayEn,
  output logic [6:0] segOut
);
  stepStrobes_t strobes;

  button_conditioner #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_CYCLES(STABLE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .buttonRaw(buttonRaw),
    .strobes  (strobes)
  );

  speed_datapath u_dp (
    .clk    (clk),
    .strobes(strobes),
    .relayEn(relayEn),
    .segOut (segOut)
  );
endmodule

// File: tb/sim_fan_speed_stepper.sv
`timescale 1ns/1ps
module sim_fan_speed_stepper;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       buttonRaw = 1'b0;
  logic [4:0] relayEn;
  logic [6:0] segOut;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fan_speed_stepper #(.SYNC_STAGES(2), .STABLE_CYCLES(S)) u0 (
    .clk(clk), .rst(rst), .buttonRaw(buttonRaw),
    .relayEn(relayEn), .segOut(segOut)
  );

  function automatic logic [4:0] expRelay(input int n);
    return (n == 0) ? 5'b0 : 5'(1 << (n - 1));
  endfunction

  function automatic logic [6:0] expSeg(input int n);
    case (n)
      0: return 7'h7E;
      1: return 7'h30;
      2: return 7'h6D;
      3: return 7'h79;
      4: return 7'h33;
      5: return 7'h5B;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check(relayEn == expRelay(model), req, relayEn, expRelay(model));
    check(segOut == expSeg(model), req, segOut, expSeg(model));
  endtask

  task automatic bounce(input bit level);
    int bursts = int'($urandom_range(1, 3));
    for (int b = 0; b < bursts; b++) begin
      buttonRaw = level;
      repeat ($urandom_range(1, S - 3)) @(negedge clk);
      buttonRaw = ~level;
      repeat ($urandom_range(1, S - 3)) @(negedge clk);
    end
  endtask

  task automatic doPress(input int hold, input bit bouncy);
    if (bouncy) bounce(1'b1);
    buttonRaw = 1'b1;
    repeat (hold) @(negedge clk);
    if (bouncy) bounce(1'b0);
    buttonRaw = 1'b0;
    repeat (S + 8) @(negedge clk);
    model = (model + 1) % 6;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checkOutputs("R1 reset");

    // R6: short glitches only, no advance
    bounce(1'b1);
    buttonRaw = 1'b0;
    repeat (S + 8) @(negedge clk);
    checkOutputs("R6 glitch ignored");

    // R8: latency window of one clean press
    buttonRaw = 1'b1;
    repeat (S) @(negedge clk);
    checkOutputs("R8 not early");
    model = 1;
    repeat (5) @(negedge clk);
    checkOutputs("R8 on time");
    // R7: release gives no further step
    buttonRaw = 1'b0;
    repeat (S + 8) @(negedge clk);
    checkOutputs("R7 release");

    // R2, R4, R5: step through every speed, then R3 wrap
    for (int k = 0; k < 4; k++) begin
      doPress(S + 6, 1'b0);
      checkOutputs("R2 R4 R5 step");
    end
    check(model == 5, "R2 top reached", model, 5);
    doPress(S + 6, 1'b0);
    checkOutputs("R3 wrap to off");

    // R7: very long hold advances once
    buttonRaw = 1'b1;
    repeat (S * 6) @(negedge clk);
    model = 1;
    checkOutputs("R7 long hold");
    buttonRaw = 1'b0;
    repeat (S + 8) @(negedge clk);
    checkOutputs("R7 long release");

    // Random presses with bounce, several wraps
    for (int k = 0; k < 40; k++) begin
      doPress(int'($urandom_range(S + 6, S + 30)), 1'b1);
      checkOutputs("R2 R3 R6 random");
    end

    // R9: reset from a nonzero speed
    while (model == 0) begin
      doPress(S + 6, 1'b0);
    end
    checkOutputs("R9 before reset");
    rst = 1'b1;
    @(negedge clk);
    model = 0;
    check(relayEn == 5'b0, "R9 relays cleared", relayEn, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checkOutputs("R9 after reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule